// File: doc/BRIEF.md
# ADC Step Sequencer with Result Queue

The block steps through a short, programmable list of conversion steps for an analog-to-digital converter and queues each result for software. A 16-bit control word holds one 4-bit field per step. Each field chooses temperature-sensor input, differential mode, an interrupt on completion, and whether the sequence stops after that step. A trigger in idle starts the list at step 0. Every step raises a request to the converter and waits for a one-cycle result-valid strobe carrying the data. The list stops at the first step that carries a stop flag, or after the last step if none does.

Results go into a four-entry, 10-bit-wide queue and are read oldest first. A status word shows the read and write pointers together with the full and empty flags. Two sticky flags record a result dropped on a full queue and a read from an empty queue. Software clears each flag by writing a 1 to its clear input.

Top module: `adc_step_seq`

## Requirements
- R1: Step n takes its settings from `ctrl_word[4n+3:4n]`: bit 3 selects the temperature sensor, bit 2 enables the interrupt, bit 1 stops the sequence, bit 0 selects differential mode. While `conv_req` is high, `conv_sel` gives the step index and `conv_temp`/`conv_diff` give that step's bits 3 and 0.
- R2: A `trig` pulse in idle raises `conv_req` with `conv_sel` = 0 in the next cycle. Each cycle in which `conv_rdy` is high while `conv_req` is high completes the current step and moves to the next step.
- R3: The sequence ends with the first step whose stop bit is set. That step may be step 0, step 3 or any step between them. `conv_req` is low in the cycle after that step completes.
- R4: If no stop bit is set, the sequence ends after step 3.
- R5: A `trig` while a sequence is running has no effect: the step index and the request stay unchanged.
- R6: Each completed step writes `conv_data` into the queue. `rd_en` pops the oldest entry onto `rd_data` in the next cycle, so results come out in step order.
- R7: `stat_word` holds the read pointer in bits [3:0], the write pointer in bits [7:4], empty in bit 8 and full in bit 12. All other bits are zero. The reset value is 0x0100.
- R8: A result that arrives while the queue holds 4 entries is dropped, the queue contents and pointers do not change, and `ovf` is set and stays set.
- R9: A read of an empty queue sets `udf`, which stays set. `rd_data` and the pointers do not change.
- R10: `clr_ovf` and `clr_udf` clear their flags. A new event in the same cycle wins over the clear.
- R11: `irq` is high for exactly one cycle, the cycle after a step completes, when that step's interrupt bit is set. It is low otherwise.
- R12: After reset `conv_req`, `irq`, `ovf`, `udf` and `rd_data` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_word | input | 16 | Step settings, one 4-bit field per step |
| trig | input | 1 | Starts a sequence when idle |
| conv_req | output | 1 | Conversion request for the current step |
| conv_sel | output | 2 | Index of the current step |
| conv_temp | output | 1 | Current step selects the temperature sensor |
| conv_diff | output | 1 | Current step uses differential mode |
| conv_rdy | input | 1 | Result valid strobe from the converter |
| conv_data | input | 10 | Conversion result |
| irq | output | 1 | Step-complete interrupt pulse |
| rd_en | input | 1 | Pop the oldest result |
| rd_data | output | 10 | Last popped result |
| stat_word | output | 16 | Pointers and full/empty flags |
| ovf | output | 1 | Sticky overflow flag |
| udf | output | 1 | Sticky underflow flag |
| clr_ovf | input | 1 | Write-1 clear for `ovf` |
| clr_udf | input | 1 | Write-1 clear for `udf` |

## Verification
A step counter that skips or repeats a step is visible on `conv_sel` and on `conv_temp`/`conv_diff` in the cycle after the faulty handshake. A late stop is visible as `conv_req` staying high one cycle too long. Pointer or count errors in the queue appear in `stat_word` in the cycle after the push or pop that caused them. A wrong memory slot appears on `rd_data` the cycle after the matching read. The bench sweeps all sixteen patterns of stop bits with varied interrupt and mode bits, and compares every step, status word and read against an arithmetic model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int unsigned STAT_EMPTY_BIT = 8;
  localparam int unsigned STAT_FULL_BIT  = 12;

  // one per-step field, most significant first
  typedef struct packed {
    logic ts;
    logic ie;
    logic fin;
    logic dif;
  } step_cfg_t;

  typedef enum logic {SQ_IDLE, SQ_RUN} sq_state_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned STEPS = 4,
  parameter int unsigned DW    = 10,
  localparam int unsigned CW   = 4 * STEPS,
  localparam int unsigned SW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl_word,
  input  logic          trig,
  input  logic          conv_rdy,
  input  logic [DW-1:0] conv_data,
  output logic          conv_req,
  output logic [SW-1:0] conv_sel,
  output logic          conv_temp,
  output logic          conv_diff,
  output logic          push,
  output logic [DW-1:0] push_data,
  output logic          irq
);
  sq_state_t     state_q, state_d;
  logic [SW-1:0] step_q, step_d;
  logic          irq_q, irq_d;
  step_cfg_t     cfg [STEPS];
  step_cfg_t     cur;

  for (genvar g = 0; g < STEPS; g++) begin : g_dec
    assign cfg[g] = step_cfg_t'(ctrl_word[4*g +: 4]);
  end

  assign cur       = cfg[step_q];
  assign conv_req  = (state_q == SQ_RUN);
  assign conv_sel  = step_q;
  assign conv_temp = conv_req & cur.ts;
  assign conv_diff = conv_req & cur.dif;
  assign push      = conv_req & conv_rdy;
  assign push_data = conv_data;
  assign irq       = irq_q;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    irq_d   = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (trig) begin
          state_d = SQ_RUN;
          step_d  = '0;
        end
      end
      SQ_RUN: begin
        if (conv_rdy) begin
          irq_d = cur.ie;
          if (cur.fin || step_q == SW'(STEPS - 1)) state_d = SQ_IDLE;
          else                                     step_d  = step_q + SW'(1);
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= '0;
      irq_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      irq_q   <= irq_d;
    end
  end
endmodule

// File: rtl/adc_res_fifo.sv
module adc_res_fifo #(
  parameter int unsigned DW    = 10,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned NW   = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          clr_ovf,
  input  logic          clr_udf,
  output logic [DW-1:0] rd_data,
  output logic [PW-1:0] rptr,
  output logic [PW-1:0] wptr,
  output logic          empty,
  output logic          full,
  output logic          ovf,
  output logic          udf
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [PW-1:0] rptr_q, rptr_d, wptr_q, wptr_d;
  logic [NW-1:0] cnt_q, cnt_d;
  logic [DW-1:0] rd_q, rd_d;
  logic          ovf_q, ovf_d, udf_q, udf_d;
  logic          wr_ok, rd_ok;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  assign full  = (cnt_q == NW'(DEPTH));
  assign empty = (cnt_q == '0);
  assign wr_ok = push & ~full;
  assign rd_ok = pop & ~empty;

  always_comb begin
    wptr_d = wr_ok ? bump(wptr_q) : wptr_q;
    rptr_d = rd_ok ? bump(rptr_q) : rptr_q;
    case ({wr_ok, rd_ok})
      2'b10:   cnt_d = cnt_q + NW'(1);
      2'b01:   cnt_d = cnt_q - NW'(1);
      default: cnt_d = cnt_q;
    endcase
    rd_d  = rd_ok ? mem_q[rptr_q] : rd_q;
    ovf_d = (push & full)  | (ovf_q & ~clr_ovf);
    udf_d = (pop  & empty) | (udf_q & ~clr_udf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr_q <= '0;
      wptr_q <= '0;
      cnt_q  <= '0;
      rd_q   <= '0;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      rptr_q <= rptr_d;
      wptr_q <= wptr_d;
      cnt_q  <= cnt_d;
      rd_q   <= rd_d;
      ovf_q  <= ovf_d;
      udf_q  <= udf_d;
    end
  end

  // storage carries no reset; only written slots are ever read
  always_ff @(posedge clk) begin
    if (wr_ok) mem_q[wptr_q] <= push_data;
  end

  assign rd_data = rd_q;
  assign rptr    = rptr_q;
  assign wptr    = wptr_q;
  assign ovf     = ovf_q;
  assign udf     = udf_q;
endmodule

// File: rtl/adc_step_seq.sv
module adc_step_seq
  import adc_seq_pkg::*;
#(
  parameter int unsigned STEPS = 4,
  parameter int unsigned DW    = 10,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CW   = 4 * STEPS,
  localparam int unsigned SW   = (STEPS > 1) ? $clog2(STEPS) : 1,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctrl_word,
  input  logic          trig,
  output logic          conv_req,
  output logic [SW-1:0] conv_sel,
  output logic          conv_temp,
  output logic          conv_diff,
  input  logic          conv_rdy,
  input  logic [DW-1:0] conv_data,
  output logic          irq,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic [15:0]   stat_word,
  output logic          ovf,
  output logic          udf,
  input  logic          clr_ovf,
  input  logic          clr_udf
);
  logic          push;
  logic [DW-1:0] push_data;
  logic [PW-1:0] rptr, wptr;
  logic          empty, full;

  adc_seq_ctrl #(.STEPS(STEPS), .DW(DW)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_word (ctrl_word),
    .trig      (trig),
    .conv_rdy  (conv_rdy),
    .conv_data (conv_data),
    .conv_req  (conv_req),
    .conv_sel  (conv_sel),
    .conv_temp (conv_temp),
    .conv_diff (conv_diff),
    .push      (push),
    .push_data (push_data),
    .irq       (irq)
  );

  adc_res_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_data (push_data),
    .pop       (rd_en),
    .clr_ovf   (clr_ovf),
    .clr_udf   (clr_udf),
    .rd_data   (rd_data),
    .rptr      (rptr),
    .wptr      (wptr),
    .empty     (empty),
    .full      (full),
    .ovf       (ovf),
    .udf       (udf)
  );

  always_comb begin
    stat_word                 = '0;
    stat_word[3:0]            = 4'(rptr);
    stat_word[7:4]            = 4'(wptr);
    stat_word[STAT_EMPTY_BIT] = empty;
    stat_word[STAT_FULL_BIT]  = full;
  end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
  parameter int unsigned STEPS = 4,
  localparam int unsigned CW   = 4 * STEPS,
  localparam int unsigned SW   = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [CW-1:0] ctrl_word,
  input logic          trig,
  input logic          conv_req,
  input logic [SW-1:0] conv_sel,
  input logic          conv_rdy,
  input logic          irq,
  input logic          rd_en,
  input logic [15:0]   stat_word,
  input logic          ovf,
  input logic          udf,
  input logic          clr_ovf,
  input logic          clr_udf
);
  // R7
  empty_ptrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stat_word[8] |-> (stat_word[3:0] == stat_word[7:4]) && !stat_word[12]
                     && stat_word[15:13] == 3'b0 && stat_word[11:9] == 3'b0);

  // R11
  irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(conv_req && conv_rdy));

  // R5
  hold_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && !conv_rdy |=> conv_req && $stable(conv_sel));

  // R3
  stop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    conv_req && conv_rdy && ctrl_word[{conv_sel, 2'b01}] |=> !conv_req);

  // R2
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !conv_req && !trig |=> !conv_req);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf && !clr_ovf |=> ovf);

  // R9
  udf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && stat_word[8] |=> udf);

  // R10
  udf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_udf && !(rd_en && stat_word[8]) |=> !udf);
endmodule

bind adc_step_seq adc_seq_chk #(.STEPS(STEPS)) u_chk (.*);

// File: tb/sim_adc_step_seq.sv
module sim_adc_step_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ctrl_word = '0;
  logic        trig = 1'b0;
  logic        conv_req;
  logic [1:0]  conv_sel;
  logic        conv_temp, conv_diff;
  logic        conv_rdy = 1'b0;
  logic [9:0]  conv_data = '0;
  logic        irq;
  logic        rd_en = 1'b0;
  logic [9:0]  rd_data;
  logic [15:0] stat_word;
  logic        ovf, udf;
  logic        clr_ovf = 1'b0, clr_udf = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  int mdl_mem [4];
  int mdl_cnt = 0, mdl_rp = 0, mdl_wp = 0, mdl_rd = 0;
  bit mdl_ovf = 0, mdl_udf = 0;

  always #5 clk = ~clk;

  adc_step_seq u0 (.*);

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_fail++;
      $display("FIFO watchdog FAIL: run did not finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at cycle %0d", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] mdl_stat();
    return {3'b0, mdl_cnt == 4, 3'b0, mdl_cnt == 0, 4'(mdl_wp), 4'(mdl_rp)};
  endfunction

  task automatic chk_stat(input string req);
    chk(stat_word === mdl_stat(), req, int'(stat_word), int'(mdl_stat()));
  endtask

  task automatic run_seq(input logic [15:0] cw, input int tag, input bit poke);
    int last = 3;
    bit hit = 0;
    ctrl_word = cw;
    for (int s = 0; s < 4; s++) if (!hit && cw[4*s+1]) begin last = s; hit = 1; end
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    for (int s = 0; s <= last; s++) begin
      int d = (tag * 4 + s) % 1024;
      chk(conv_req === 1'b1, "R2", int'(conv_req), 1);
      chk(conv_sel === 2'(s), "R2", int'(conv_sel), s);
      chk({conv_temp, conv_diff} === {cw[4*s+3], cw[4*s]}, "R1",
          int'({conv_temp, conv_diff}), int'({cw[4*s+3], cw[4*s]}));
      if (poke && s == 1) begin
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
        chk(conv_req === 1'b1 && conv_sel === 2'd1, "R5", int'(conv_sel), 1);
      end
      conv_rdy  = 1'b1;
      conv_data = 10'(d);
      @(negedge clk);
      conv_rdy = 1'b0;
      chk(irq === cw[4*s+2], "R11", int'(irq), int'(cw[4*s+2]));
      if (mdl_cnt < 4) begin
        mdl_mem[mdl_wp] = d;
        mdl_wp = (mdl_wp + 1) % 4;
        mdl_cnt++;
      end else mdl_ovf = 1;
      chk_stat(mdl_cnt == 4 ? "R8" : "R6");
      chk(ovf === mdl_ovf, "R8", int'(ovf), int'(mdl_ovf));
    end
    chk(conv_req === 1'b0, hit ? "R3" : "R4", int'(conv_req), 0);
    @(negedge clk);
    chk(irq === 1'b0, "R11", int'(irq), 0);
    chk(conv_req === 1'b0, hit ? "R3" : "R4", int'(conv_req), 0);
  endtask

  task automatic rd_one(input bit clr_u_too);
    rd_en   = 1'b1;
    clr_udf = clr_u_too;
    @(negedge clk);
    rd_en   = 1'b0;
    clr_udf = 1'b0;
    if (mdl_cnt > 0) begin
      mdl_rd = mdl_mem[mdl_rp];
      mdl_rp = (mdl_rp + 1) % 4;
      mdl_cnt--;
      chk(rd_data === 10'(mdl_rd), "R6", int'(rd_data), mdl_rd);
    end else begin
      mdl_udf = 1;
      chk(rd_data === 10'(mdl_rd), "R9", int'(rd_data), mdl_rd);
    end
    chk(udf === mdl_udf, clr_u_too ? "R10" : "R9", int'(udf), int'(mdl_udf));
    chk_stat("R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R12 / R7: reset values
    chk(conv_req === 1'b0 && irq === 1'b0, "R12", int'({conv_req, irq}), 0);
    chk(ovf === 1'b0 && udf === 1'b0, "R12", int'({ovf, udf}), 0);
    chk(rd_data === 10'd0, "R12", int'(rd_data), 0);
    chk(stat_word === 16'h0100, "R7", int'(stat_word), 'h100);
    rst_n = 1'b1;
    @(negedge clk);

    // all stop-bit patterns, varied interrupt and mode bits
    for (int e = 0; e < 16; e++) begin
      logic [15:0] cw = '0;
      int n;
      for (int s = 0; s < 4; s++) begin
        cw[4*s+3] = 1'((e + s) & 1);
        cw[4*s+2] = 1'(((e ^ 5) >> s) & 1);
        cw[4*s+1] = 1'((e >> s) & 1);
        cw[4*s]   = 1'(((e >> 1) + s + 1) & 1);
      end
      run_seq(cw, e + 1, e == 0 || e == 12);
      n = mdl_cnt;
      for (int k = 0; k < n; k++) rd_one(0);
      chk(stat_word[8] === 1'b1, "R6", int'(stat_word), int'(mdl_stat()));
    end

    // fill, then overflow on a full queue
    run_seq(16'h0000, 100, 0);
    chk(stat_word[12] === 1'b1, "R7", int'(stat_word), int'(mdl_stat()));
    run_seq(16'h0000, 200, 0);
    chk(ovf === 1'b1, "R8", int'(ovf), 1);
    for (int k = 0; k < 4; k++) rd_one(0);
    chk(ovf === 1'b1, "R8", int'(ovf), 1);

    // underflow, set wins over clear, then clears
    rd_one(0);
    rd_one(1);
    clr_udf = 1'b1;
    @(negedge clk);
    clr_udf = 1'b0;
    mdl_udf = 0;
    chk(udf === 1'b0, "R10", int'(udf), 0);
    clr_ovf = 1'b1;
    @(negedge clk);
    clr_ovf = 1'b0;
    mdl_ovf = 0;
    chk(ovf === 1'b0, "R10", int'(ovf), 0);
    chk_stat("R9");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule